// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Register Port

This block drives a multi-channel successive-approximation converter from a small register port. Software picks an input channel and, in the same control write, switches the converter on. The block then waits a programmable number of clock cycles so the analog side can settle. After that it resolves the sample one bit per cycle, most significant bit first. For each trial code it places on the DAC output, it reads back a single comparator bit.

When the last bit has been resolved, the result is stored in a read-only data register. A completion flag is set and, if enabled, an interrupt is raised. A status register shows whether a conversion is under way. Writing zero to the control register clears the completion flag and switches the converter off. A control write that arrives during a conversion cancels it. The converter clock is the register-port clock. The analog comparator and the DAC are outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the data register, the status register and the control register read 0, the delay register reads 8, `irq` is 0, `adc_pwr` is 0 and `dac_code` is 0.
- R2: The registers sit at these offsets: 0x00 holds the result (read-only), 0x04 holds the status (bit 0 is busy, read-only), 0x08 holds the control register and 0x0C holds the delay register. Reads of any other offset return 0. Writes to other offsets, to 0x00 and to 0x04 change no register.
- R3: The control register fields are: bits 2:0 channel, bit 3 power, bit 5 interrupt enable and bit 6 completion flag. A control write made while idle, with bit 3 set and a channel below `NUM_CH`, starts a conversion. Status bit 0 then reads 1 from the next cycle. `adc_chan` shows the written channel and `adc_pwr` shows bit 3.
- R4: Only bits 5:0 of the delay register are stored. A conversion stays busy for exactly D + `RES_W` cycles after the starting write, where D is the stored delay. When D is 0, no wait cycles are inserted.
- R5: In each conversion cycle, `dac_code` shows the bits decided so far with the current bit set as a trial, starting at the MSB. The trial bit is kept when `cmp_in` is 1 and cleared when it is 0. The final code is therefore the largest value whose trial was accepted, which for an ideal comparator is the input level.
- R6: At the end of a conversion, the result is stored zero-extended in the data register, and control bit 6 is set in the same cycle that busy falls.
- R7: `irq` equals control bit 6 AND control bit 5.
- R8: Every control write clears bit 6. Writing 0 to the control register drops `irq` and `adc_pwr`.
- R9: A control write made while busy cancels the conversion. The block is idle on the next cycle, the data register keeps its old value, and bit 6 stays clear.
- R10: A control write made while idle, with bit 3 clear or with a channel of `NUM_CH` or more, starts no conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | RES_W | Trial code for the DAC, 0 outside conversion |
| adc_chan | output | 3 | Selected input channel |
| adc_pwr | output | 1 | Converter power enable |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer state shows up as a busy window that is longer or shorter than D + RES_W cycles. The bench counts this window at the status register on every cycle, so a mistake is caught within one conversion. A wrong bit index or a wrong keep/clear decision gives a result that differs from the analog level the bench modelled, and this is visible as soon as the data register is read. A broken cancel or a broken channel guard shows up one cycle after the write, either as busy staying high or as the data register or `irq` changing when it should not.

// File: rtl/sar_adc_pkg.sv
// Shared types and register constants for the SAR ADC sequencer.
// Assumes byte offsets fit in 8 bits.
package sar_adc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

    localparam logic [7:0] OFF_RESULT = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_DELAY  = 8'h0C;

    localparam int CTRL_PWR_BIT = 3;
    localparam int CTRL_IE_BIT  = 5;
    localparam int CTRL_IS_BIT  = 6;
endpackage

// File: rtl/sar_apb_regs.sv
// Register file and write decode for the SAR ADC sequencer.
// What it does: decodes reads and writes, holds channel/power/enable/flag,
// the delay and the result, and produces one-cycle start and abort pulses.
// Assumes: single-cycle accesses (no wait states); read data depends only on paddr.
module sar_apb_regs
    import sar_adc_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int RES_W   = 10,
    parameter int NUM_CH  = 3,
    parameter int DLY_W   = 6,
    parameter int DLY_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic              busy,
    input  logic              done,
    input  logic [RES_W-1:0]  result,
    output logic [31:0]       prdata,
    output logic [2:0]        chan,
    output logic              pwr,
    output logic              ie,
    output logic              sts,
    output logic [DLY_W-1:0]  dly,
    output logic [RES_W-1:0]  data_val,
    output logic              start,
    output logic              abort
);
    logic wr_en, ctrl_wr, dly_wr, chan_ok;

    // Purpose: decode the write strobes and derive the start/abort pulses.
    always_comb begin
        wr_en   = psel && penable && pwrite;
        ctrl_wr = wr_en && (paddr == OFF_CTRL[ADDR_W-1:0]);
        dly_wr  = wr_en && (paddr == OFF_DELAY[ADDR_W-1:0]);
        chan_ok = int'(pwdata[2:0]) < NUM_CH;
        start   = ctrl_wr && pwdata[CTRL_PWR_BIT] && chan_ok && !busy;
        abort   = ctrl_wr && busy;
    end

    // Purpose: update the control fields and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan <= '0;
            pwr  <= 1'b0;
            ie   <= 1'b0;
            sts  <= 1'b0;
        end else if (ctrl_wr) begin
            chan <= pwdata[2:0];
            pwr  <= pwdata[CTRL_PWR_BIT];
            ie   <= pwdata[CTRL_IE_BIT];
            sts  <= 1'b0;
        end else if (done) begin
            sts  <= 1'b1;
        end
    end

    // Purpose: hold the power-up delay, keeping only its low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly <= DLY_W'(DLY_RST);
        else if (dly_wr)
            dly <= pwdata[DLY_W-1:0];
    end

    // Purpose: latch the final code when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_val <= '0;
        else if (done)
            data_val <= result;
    end

    // Purpose: read multiplexer; undefined offsets read as zero.
    always_comb begin
        prdata = '0;
        if (paddr == OFF_RESULT[ADDR_W-1:0])
            prdata = {{(32-RES_W){1'b0}}, data_val};
        else if (paddr == OFF_STATUS[ADDR_W-1:0])
            prdata = {31'b0, busy};
        else if (paddr == OFF_CTRL[ADDR_W-1:0])
            prdata = {25'b0, sts, ie, 1'b0, pwr, chan};
        else if (paddr == OFF_DELAY[ADDR_W-1:0])
            prdata = {{(32-DLY_W){1'b0}}, dly};
    end
endmodule

// File: rtl/sar_seq.sv
// Conversion sequencer: idle -> settle wait -> bit-by-bit conversion.
// What it does: counts the power-up delay, then steps the bit index from MSB to 0.
// Assumes: start is only pulsed while idle; abort has priority over every state.
module sar_seq
    import sar_adc_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int DLY_W = 6,
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] dly,
    output logic             busy,
    output logic             conv,
    output logic             done,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_W - 1);

    seq_state_t       state;
    logic [DLY_W-1:0] wait_cnt;

    // Purpose: advance the sequencer state, the delay count and the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            bit_idx  <= '0;
        end else if (abort) begin
            state    <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    bit_idx <= MSB_IDX;
                    if (dly == '0) begin
                        state <= ST_CONV;
                    end else begin
                        state    <= ST_WAIT;
                        wait_cnt <= dly;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == DLY_W'(1))
                        state <= ST_CONV;
                    else
                        wait_cnt <= wait_cnt - 1'b1;
                end
                ST_CONV: begin
                    if (bit_idx == '0)
                        state <= ST_IDLE;
                    else
                        bit_idx <= bit_idx - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode the status outputs from the state.
    always_comb begin
        busy = (state != ST_IDLE);
        conv = (state == ST_CONV);
        done = conv && (bit_idx == '0) && !abort;
    end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register.
// What it does: forms the trial code and keeps or clears the trial bit from the comparator.
// Assumes: the bit index counts down from the MSB; the register is cleared at start.
module sar_approx #(
    parameter int RES_W = 10,
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             conv,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] trial;

    // Purpose: build the trial code and the code after this cycle's decision.
    always_comb begin
        trial           = sar_q | (RES_W'(1) << bit_idx);
        result          = sar_q;
        result[bit_idx] = cmp_in;
        dac_code        = conv ? trial : '0;
    end

    // Purpose: clear at start, then record one decided bit per conversion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sar_q <= '0;
        else if (start)
            sar_q <= '0;
        else if (conv)
            sar_q <= result;
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
// Top level of the SAR ADC sequencer.
// What it does: joins the register file, the sequencer and the approximation register.
// Assumes: one clock serves both the register port and the converter; NUM_CH <= 8.
module sar_adc_ctrl #(
    parameter int ADDR_W  = 5,
    parameter int RES_W   = 10,
    parameter int NUM_CH  = 3,
    parameter int DLY_W   = 6,
    parameter int DLY_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic [2:0]        adc_chan,
    output logic              adc_pwr,
    output logic              irq
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic             busy, conv, done, start, abort;
    logic             ie, sts;
    logic [DLY_W-1:0] dly;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] result, data_val;

    sar_apb_regs #(
        .ADDR_W(ADDR_W), .RES_W(RES_W), .NUM_CH(NUM_CH),
        .DLY_W(DLY_W), .DLY_RST(DLY_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .busy(busy), .done(done), .result(result),
        .prdata(prdata), .chan(adc_chan), .pwr(adc_pwr), .ie(ie),
        .sts(sts), .dly(dly), .data_val(data_val),
        .start(start), .abort(abort)
    );

    sar_seq #(.RES_W(RES_W), .DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .dly(dly),
        .busy(busy), .conv(conv), .done(done), .bit_idx(bit_idx)
    );

    sar_approx #(.RES_W(RES_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(start), .conv(conv),
        .bit_idx(bit_idx), .cmp_in(cmp_in),
        .dac_code(dac_code), .result(result)
    );

    // Purpose: interrupt is the completion flag gated by its enable.
    always_comb irq = sts && ie;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// Property checker for sar_adc_ctrl, attached with bind.
// Assumes: the signal names of the top module's internal wires.
module sar_adc_ctrl_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             start,
    input logic             abort,
    input logic             sts,
    input logic             irq,
    input logic             adc_pwr,
    input logic [RES_W-1:0] data_val
);
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    p_busy_powered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> adc_pwr);

    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sts && !busy));

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done));

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !sts));

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(data_val));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .start(start),
    .abort(abort), .sts(sts), .irq(irq), .adc_pwr(adc_pwr),
    .data_val(data_val)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
    localparam int RES_W = 10;

    typedef struct packed {
        logic [2:0] ch;
        logic [5:0] dly;
        logic [9:0] ain;
        logic       ie;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 6'd0,  10'd0,    1'b1},
        '{3'd1, 6'd8,  10'd1023, 1'b1},
        '{3'd2, 6'd1,  10'd512,  1'b0},
        '{3'd0, 6'd63, 10'd511,  1'b1},
        '{3'd1, 6'd3,  10'd341,  1'b1},
        '{3'd2, 6'd8,  10'd682,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic cmp_in;
    logic [RES_W-1:0] dac_code;
    logic [2:0] adc_chan;
    logic adc_pwr, irq;
    logic [RES_W-1:0] ain = '0;
    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    // ideal comparator: input at or above the trial code
    assign cmp_in = (dac_code <= ain);

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cmp_in(cmp_in), .dac_code(dac_code), .adc_chan(adc_chan),
        .adc_pwr(adc_pwr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        paddr = a;
        #1;
        d = prdata;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h00, r); chk("R1 data", r, 0);
        rd(5'h04, r); chk("R1 status", r, 0);
        rd(5'h08, r); chk("R1 ctrl", r, 0);
        rd(5'h0C, r); chk("R1 delay", r, 8);
        chk("R1 irq/pwr/dac", {irq, adc_pwr, 22'b0, dac_code}, 0);

        // table of conversions: R3 R4 R5 R6 R7 R8
        foreach (VEC[i]) begin
            ain = VEC[i].ain;
            wr(5'h0C, {26'b0, VEC[i].dly});
            wr(5'h08, {26'b0, VEC[i].ie, 2'b01, VEC[i].ch});
            rd(5'h04, r);
            chk("R3 busy after start", r, 1);
            chk("R3 chan/pwr", {adc_chan, adc_pwr}, {VEC[i].ch, 1'b1});
            n = 0;
            while (r[0] && n < 200) begin
                @(negedge clk);
                n++;
                rd(5'h04, r);
            end
            chk("R4 busy cycles", n, VEC[i].dly + RES_W);
            rd(5'h00, r); chk("R5 R6 result", r, {22'b0, VEC[i].ain});
            rd(5'h08, r); chk("R6 flag", r[6], 1);
            chk("R7 irq", irq, VEC[i].ie);
            wr(5'h08, 0);
            rd(5'h08, r); chk("R8 flag cleared", r, 0);
            chk("R8 irq/pwr low", {irq, adc_pwr}, 0);
        end

        // R9: cancel a running conversion
        ain = 10'd100;
        wr(5'h0C, 8);
        wr(5'h08, 32'h29);
        repeat (12) @(negedge clk);
        wr(5'h08, 32'h29);
        rd(5'h04, r); chk("R9 idle after abort", r, 0);
        repeat (20) @(negedge clk);
        rd(5'h04, r); chk("R9 stays idle", r, 0);
        rd(5'h00, r); chk("R9 data kept", r, 682);
        rd(5'h08, r); chk("R9 flag clear", r[6], 0);
        chk("R9 no irq", irq, 0);

        // R10: bad channel, and power bit clear
        wr(5'h08, 32'h2B);
        rd(5'h04, r); chk("R10 channel 3 no start", r, 0);
        wr(5'h08, 32'h21);
        rd(5'h04, r); chk("R10 power clear no start", r, 0);
        repeat (20) @(negedge clk);
        rd(5'h00, r); chk("R10 data kept", r, 682);
        chk("R10 no irq", irq, 0);

        // R2: undefined offsets and read-only registers
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, r); chk("R2 undefined read", r, 0);
        rd(5'h14, r); chk("R2 undefined read 14", r, 0);
        rd(5'h0C, r); chk("R2 delay untouched", r, 8);
        wr(5'h00, 32'h155);
        rd(5'h00, r); chk("R2 data read-only", r, 682);
        wr(5'h04, 32'h1);
        rd(5'h04, r); chk("R2 status read-only", r, 0);

        // R4: delay keeps only its low bits
        wr(5'h0C, 32'hFFFF_FFC5);
        rd(5'h0C, r); chk("R4 delay mask", r, 5);

        finish_run();
    end
endmodule